// File: doc/BRIEF.md
# Timed Access Write Guard

This block keeps chosen control-register bits from being changed by a stray or runaway write. It watches the register write bus for writes to one dedicated key address. Software opens a short write window by writing a first key byte and then, on the cycle immediately after, a second key byte. While the window is open, a write to any guarded register may change all of its bits. Outside the window, the guarded bits of those registers are masked off and only the unguarded bits may change.

The block drives two things to the guarded registers in the same cycle as a write: a one-hot select naming which guarded register is addressed, and a per-bit write enable. The registers themselves sit outside this block and load only the bits whose enable is high. Guarded addresses and the guarded-bit mask of each are parameters, and so is the window length. The sequencer state and the last byte written to the key address can be read back at the ports.

Top module: `timed_access_guard`

## Requirements
- R1: After reset, `seq_state` is 0 (idle), `window_open` is 0 and `ta_value` is 0xFF.
- R2: A write to the key address `TA_ADDR` stores its data byte, and `ta_value` shows it from the next cycle on.
- R3: From idle (0) or open (2), a key-address write of 0xAA puts `seq_state` at 1 on the next cycle; any other byte written there puts it at 0.
- R4: In state 1, only a key-address write of 0x55 in that same single cycle moves `seq_state` to 2 (open); another byte, or no key write in that cycle, returns it to 0.
- R5: The window stays open for at most `WINDOW` cycles (default 4); if no guarded write arrives, `seq_state` returns to 0 after the last of them.
- R6: A write to guarded register i (address field i of `PROT_ADDRS`) sets bit i of `prot_sel`; `prot_sel` is all zero for any other address or with `wr_en` low, and never has more than one bit set.
- R7: With the window closed, a guarded write gets `wr_bit_en` equal to the inverse of its mask (field i of `PROT_MASKS`), so every guarded bit keeps its old value.
- R8: With the window open, a guarded write gets `wr_bit_en` all ones, and the window closes on the next cycle (`seq_state` 0).
- R9: Writes to addresses that are neither the key address nor a guarded address change neither the window nor the sequencer state, apart from the timeouts of R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| prot_sel | output | NUM_PROT | One-hot select of the addressed guarded register |
| wr_bit_en | output | 8 | Per-bit write enable for the addressed guarded register |
| window_open | output | 1 | High while guarded bits may be written |
| seq_state | output | 2 | Sequencer state: 0 idle, 1 first key seen, 2 open |
| ta_value | output | 8 | Last byte written to the key address |

## Verification
The window timeout and a guarded write can land in the same cycle: the last open cycle may carry the write that the window exists for. The bench opens the window, idles until its final cycle, writes a guarded register there and expects full bit enables in that cycle and state 0 in the next. A second overlap is a fresh first key written while the window is open, which must grant nothing further and leave state 1; random traffic that mixes key bytes, guarded writes and other addresses is compared every cycle against a bench model of the rules.

// File: rtl/tas_pkg.sv
package tas_pkg;
  localparam int TAS_DW = 8;

  typedef enum logic [1:0] {
    TAS_IDLE  = 2'd0,
    TAS_FIRST = 2'd1,
    TAS_OPEN  = 2'd2
  } tas_state_e;

  localparam logic [TAS_DW-1:0] TAS_KEY_A    = 8'hAA;
  localparam logic [TAS_DW-1:0] TAS_KEY_B    = 8'h55;
  localparam logic [TAS_DW-1:0] TAS_KEY_RST  = 8'hFF;
endpackage

// File: rtl/tas_addr_decode.sv
module tas_addr_decode #(
  parameter int                         ADDR_W     = 8,
  parameter int                         NUM_PROT   = 3,
  parameter logic [ADDR_W-1:0]          TA_ADDR    = 8'h3A,
  parameter logic [NUM_PROT*ADDR_W-1:0] PROT_ADDRS = {8'h12, 8'h11, 8'h10}
) (
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  output logic                key_hit,
  output logic [NUM_PROT-1:0] prot_hit
);
  assign key_hit = wr_en && (wr_addr == TA_ADDR);

  for (genvar g = 0; g < NUM_PROT; g++) begin : g_match
    assign prot_hit[g] = wr_en && (wr_addr == PROT_ADDRS[g*ADDR_W +: ADDR_W]);
  end
endmodule

// File: rtl/tas_key_fsm.sv
module tas_key_fsm
  import tas_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_hit,
  input  logic [TAS_DW-1:0] key_data,
  input  logic              prot_any,
  output tas_state_e        state,
  output logic [TAS_DW-1:0] key_reg
);
  localparam int CW = (WINDOW < 2) ? 1 : $clog2(WINDOW);
  localparam logic [CW-1:0] LOAD = CW'(WINDOW - 1);

  tas_state_e    state_q, state_d;
  logic [CW-1:0] left_q, left_d;

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    if (key_hit) begin
      if (state_q == TAS_FIRST) begin
        if (key_data == TAS_KEY_B) begin
          state_d = TAS_OPEN;
          left_d  = LOAD;
        end else begin
          state_d = TAS_IDLE;
        end
      end else begin
        state_d = (key_data == TAS_KEY_A) ? TAS_FIRST : TAS_IDLE;
      end
    end else begin
      unique case (state_q)
        TAS_FIRST: state_d = TAS_IDLE;
        TAS_OPEN: begin
          if (prot_any || left_q == '0) state_d = TAS_IDLE;
          else                          left_d  = left_q - 1'b1;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TAS_IDLE;
      left_q  <= '0;
      key_reg <= TAS_KEY_RST;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      if (key_hit) key_reg <= key_data;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/tas_bit_qualify.sv
module tas_bit_qualify
  import tas_pkg::*;
#(
  parameter int                         NUM_PROT   = 3,
  parameter logic [NUM_PROT*TAS_DW-1:0] PROT_MASKS = {8'hFF, 8'h81, 8'h0C}
) (
  input  logic [NUM_PROT-1:0] prot_hit,
  input  logic                open,
  output logic [TAS_DW-1:0]   bit_en
);
  logic [TAS_DW-1:0] lane [NUM_PROT];

  for (genvar g = 0; g < NUM_PROT; g++) begin : g_lane
    assign lane[g] = !prot_hit[g] ? '0 :
                     open         ? '1 : ~PROT_MASKS[g*TAS_DW +: TAS_DW];
  end

  always_comb begin
    bit_en = '0;
    for (int i = 0; i < NUM_PROT; i++) bit_en |= lane[i];
  end
endmodule

// File: rtl/timed_access_guard.sv
module timed_access_guard
  import tas_pkg::*;
#(
  parameter int                         ADDR_W     = 8,
  parameter int                         NUM_PROT   = 3,
  parameter int                         WINDOW     = 4,
  parameter logic [ADDR_W-1:0]          TA_ADDR    = 8'h3A,
  parameter logic [NUM_PROT*ADDR_W-1:0] PROT_ADDRS = {8'h12, 8'h11, 8'h10},
  parameter logic [NUM_PROT*8-1:0]      PROT_MASKS = {8'hFF, 8'h81, 8'h0C}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  output logic [NUM_PROT-1:0] prot_sel,
  output logic [7:0]          wr_bit_en,
  output logic                window_open,
  output logic [1:0]          seq_state,
  output logic [7:0]          ta_value
);
  logic       key_hit;
  tas_state_e state;

  tas_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_PROT(NUM_PROT),
    .TA_ADDR(TA_ADDR), .PROT_ADDRS(PROT_ADDRS)
  ) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr),
    .key_hit(key_hit), .prot_hit(prot_sel)
  );

  tas_key_fsm #(.WINDOW(WINDOW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .key_hit(key_hit), .key_data(wr_data),
    .prot_any(|prot_sel),
    .state(state), .key_reg(ta_value)
  );

  assign window_open = (state == TAS_OPEN);
  assign seq_state   = state;

  tas_bit_qualify #(.NUM_PROT(NUM_PROT), .PROT_MASKS(PROT_MASKS)) u_qual (
    .prot_hit(prot_sel), .open(window_open), .bit_en(wr_bit_en)
  );
endmodule

// File: rtl/timed_access_guard_chk.sv
module timed_access_guard_chk #(
  parameter int                         ADDR_W     = 8,
  parameter int                         NUM_PROT   = 3,
  parameter int                         WINDOW     = 4,
  parameter logic [ADDR_W-1:0]          TA_ADDR    = 8'h3A,
  parameter logic [NUM_PROT*8-1:0]      PROT_MASKS = {8'hFF, 8'h81, 8'h0C}
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [7:0]          wr_data,
  input logic [NUM_PROT-1:0] prot_sel,
  input logic [7:0]          wr_bit_en,
  input logic                window_open,
  input logic [1:0]          seq_state
);
  localparam int RW = $clog2(WINDOW + 2) + 1;

  logic          key_wr;
  logic [7:0]    sel_mask;
  logic [RW-1:0] open_run;

  assign key_wr = wr_en && (wr_addr == TA_ADDR);

  always_comb begin
    sel_mask = '0;
    for (int i = 0; i < NUM_PROT; i++)
      if (prot_sel[i]) sel_mask |= PROT_MASKS[i*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           open_run <= '0;
    else if (window_open) open_run <= open_run + 1'b1;
    else                  open_run <= '0;
  end

  assert_first_is_brief_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'd1) |=> (seq_state != 2'd1));

  assert_open_needs_second_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(window_open) |-> $past(key_wr && wr_data == 8'h55 && seq_state == 2'd1));

  assert_first_needs_first_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state != 2'd1) |=> ((seq_state == 2'd1) == $past(key_wr && wr_data == 8'hAA)));

  assert_window_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    open_run <= RW'(WINDOW));

  assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(prot_sel));

  assert_closed_masks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!window_open && |prot_sel) |-> ((wr_bit_en & sel_mask) == 8'h00));

  assert_write_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (window_open && |prot_sel) |=> !window_open);
endmodule

bind timed_access_guard timed_access_guard_chk #(
  .ADDR_W(ADDR_W), .NUM_PROT(NUM_PROT), .WINDOW(WINDOW),
  .TA_ADDR(TA_ADDR), .PROT_MASKS(PROT_MASKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .prot_sel(prot_sel), .wr_bit_en(wr_bit_en),
  .window_open(window_open), .seq_state(seq_state)
);

// File: tb/tb_timed_access_guard.sv
`timescale 1ns/1ps
module tb_timed_access_guard;
  localparam int        AW  = 8;
  localparam int        NP  = 3;
  localparam int        WIN = 4;
  localparam logic [7:0] KADDR = 8'h3A;
  localparam logic [7:0] OTHER = 8'h77;
  localparam logic [7:0] PA [NP] = '{8'h10, 8'h11, 8'h12};
  localparam logic [7:0] PM [NP] = '{8'h0C, 8'h81, 8'hFF};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [NP-1:0] prot_sel;
  logic [7:0]    wr_bit_en;
  logic          window_open;
  logic [1:0]    seq_state;
  logic [7:0]    ta_value;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string req = "R1";

  int m_state = 0;
  int m_left = 0;
  logic [7:0] m_ta = 8'hFF;

  always #2.5 clk = ~clk;

  timed_access_guard #(
    .ADDR_W(AW), .NUM_PROT(NP), .WINDOW(WIN), .TA_ADDR(KADDR),
    .PROT_ADDRS({8'h12, 8'h11, 8'h10}), .PROT_MASKS({8'hFF, 8'h81, 8'h0C})
  ) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .prot_sel(prot_sel), .wr_bit_en(wr_bit_en),
    .window_open(window_open), .seq_state(seq_state), .ta_value(ta_value)
  );

  function automatic logic [NP-1:0] exp_sel(input logic en, input logic [7:0] a);
    logic [NP-1:0] s = '0;
    for (int i = 0; i < NP; i++) if (en && a == PA[i]) s[i] = 1'b1;
    return s;
  endfunction

  function automatic logic [7:0] exp_bits(input logic en, input logic [7:0] a, input int st);
    for (int i = 0; i < NP; i++)
      if (en && a == PA[i]) return (st == 2) ? 8'hFF : ~PM[i];
    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic [7:0] a, input logic [7:0] d);
    int ns, nl;
    logic [7:0] nt;
    logic [NP-1:0] es;
    logic [7:0] eb;
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    #1;
    es = exp_sel(en, a);
    eb = exp_bits(en, a, m_state);
    chk(prot_sel == es, "prot_sel", int'(prot_sel), int'(es));
    chk(wr_bit_en == eb, "wr_bit_en", int'(wr_bit_en), int'(eb));
    chk(int'(seq_state) == m_state, "seq_state", int'(seq_state), m_state);
    chk(window_open == (m_state == 2), "window_open", int'(window_open), int'(m_state == 2));
    chk(ta_value == m_ta, "ta_value", int'(ta_value), int'(m_ta));
    ns = m_state; nl = m_left; nt = m_ta;
    if (en && a == KADDR) begin
      nt = d;
      if (m_state == 1) begin
        if (d == 8'h55) begin ns = 2; nl = WIN - 1; end
        else ns = 0;
      end else ns = (d == 8'hAA) ? 1 : 0;
    end else if (m_state == 2) begin
      if (es != '0 || m_left == 0) ns = 0;
      else nl = m_left - 1;
    end else if (m_state == 1) ns = 0;
    @(posedge clk);
    m_state = ns; m_left = nl; m_ta = nt;
  endtask

  task automatic idle_cycle();
    step(1'b0, 8'h00, 8'h00);
  endtask

  task automatic open_window();
    step(1'b1, KADDR, 8'hAA);
    step(1'b1, KADDR, 8'h55);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    req = "R1 reset";
    idle_cycle();

    req = "R2 key byte stored";
    step(1'b1, KADDR, 8'h37);
    idle_cycle();

    req = "R7 closed write masks guarded bits";
    for (int i = 0; i < NP; i++) step(1'b1, PA[i], 8'hA5);

    req = "R3 R4 open then R8 write closes";
    open_window();
    step(1'b1, PA[1], 8'h3C);
    idle_cycle();

    req = "R4 gap between keys";
    step(1'b1, KADDR, 8'hAA);
    idle_cycle();
    step(1'b1, KADDR, 8'h55);
    idle_cycle();

    req = "R4 repeated first key";
    step(1'b1, KADDR, 8'hAA);
    step(1'b1, KADDR, 8'hAA);
    idle_cycle();

    req = "R3 wrong first key";
    step(1'b1, KADDR, 8'h55);
    idle_cycle();

    req = "R5 window length unused";
    open_window();
    cnt = 0;
    for (int k = 0; k < WIN + 3; k++) begin
      if (window_open) cnt++;
      idle_cycle();
    end
    chk(cnt == WIN, "open cycles R5", cnt, WIN);

    req = "R5 R8 write on last window cycle";
    open_window();
    for (int k = 0; k < WIN - 1; k++) idle_cycle();
    step(1'b1, PA[0], 8'hF0);
    idle_cycle();

    req = "R9 other address keeps window";
    open_window();
    step(1'b1, OTHER, 8'h12);
    step(1'b1, OTHER, 8'h34);
    step(1'b1, PA[2], 8'h01);
    idle_cycle();

    req = "R3 new first key while open";
    open_window();
    step(1'b1, KADDR, 8'hAA);
    step(1'b1, PA[2], 8'h77);
    idle_cycle();

    req = "R9 random traffic";
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(99));
      logic [7:0] d = 8'($urandom());
      if      (r < 30) step(1'b1, KADDR, 8'hAA);
      else if (r < 50) step(1'b1, KADDR, 8'h55);
      else if (r < 57) step(1'b1, KADDR, d);
      else if (r < 80) step(1'b1, PA[$urandom_range(NP-1)], d);
      else if (r < 90) step(1'b1, OTHER ^ (d & 8'h01), d);
      else             step(1'b0, d, d);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule